// File: doc/BRIEF.md
# Protection Fault Supervisor for a PDM Amplifier Path

This block merges five protection causes into one fault that disables an amplifier's output stages. One cause comes from the digital audio input. A run-length detector watches the accepted bits of the pulse-density stream and flags stuck data when the same bit value repeats too many times in a row. The other four causes arrive as digital flags from analog comparators.

The over-temperature cause is not a plain pass-through. When its synchronised flag asserts, the block latches a lockout. A timer running on the bit clock holds that lockout for a fixed number of cycles and then releases it by itself. If the flag is still high when the timer expires, the hold starts again. The over-voltage, under-voltage and over-current flags are synchronised and passed straight through.

The PDM input is a valid/ready stream sampled on the bit clock. The block never applies back-pressure: `pdm_ready` is held high, and every beat with `pdm_valid` high is accepted. A beat with `pdm_valid` low is an idle cycle. The source may leave gaps of any length. Gaps neither add to a run nor interrupt one.

Top module: `fs_prot_supervisor`

## Requirements
- R1: After reset, `cause` is all zeros, `fault` is 0, `out_en` is 1 and `pdm_ready` is 1.
- R2: The invalid-data cause (`cause[0]`) rises right after the edge that accepts the RUN_LEN-th (default 128) consecutive identical bit. Runs of zeros and runs of ones are both detected. A run of RUN_LEN-1 identical bits does not raise it, and neither does an alternating stream.
- R3: `cause[0]` clears right after the edge that accepts a bit differing from the previous accepted bit.
- R4: Beats with `pdm_valid` low neither extend nor break a run, and they leave `cause[0]` unchanged. `pdm_ready` stays 1 at all times, so there is no back-pressure.
- R5: `cause[2]` (over-voltage), `cause[3]` (under-voltage) and `cause[4]` (over-current) follow `ov_flag`, `uv_flag` and `oc_flag` two clock edges later, on both rising and falling changes.
- R6: The cause bit order is [0] invalid data, [1] over-temperature, [2] over-voltage, [3] under-voltage, [4] over-current. `fault` is the OR of all cause bits, and `out_en` is its inverse.
- R7: `cause[1]` rises three edges after `ot_flag` rises, even if the flag is high for only one cycle. It then stays high for exactly OT_HOLD cycles and clears if the synchronised flag is low at expiry.
- R8: If the synchronised over-temperature flag is still high when the hold expires, the hold restarts for another OT_HOLD cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PDM bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdm_valid | input | 1 | A PDM bit is present this cycle |
| pdm_bit | input | 1 | PDM data bit |
| pdm_ready | output | 1 | Always 1; the block never stalls the source |
| ot_flag | input | 1 | Raw over-temperature comparator flag |
| ov_flag | input | 1 | Raw over-voltage flag |
| uv_flag | input | 1 | Raw under-voltage flag |
| oc_flag | input | 1 | Raw over-current flag |
| fault | output | 1 | At least one cause is active |
| cause | output | 5 | Per-cause status, bit order as in R6 |
| out_en | output | 1 | Output stage enable, low while any cause is active |

## Verification
Each result has a fixed due cycle, counted from the edge at which its stimulus is first sampled:
- The stuck-data cause settles on that same edge.
- The voltage and current causes settle two edges later.
- The over-temperature lockout sets three edges later and ends exactly OT_HOLD edges after it set.

The driver changes inputs just after a rising edge and counts edges to the due cycle before it queues the expected cause vector. The monitor compares the outputs at the following falling edge. Each check falls on the last cycle before a transition or on the first cycle after it, so an off-by-one in any of these counts is reported.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int CAUSE_N  = 5;
  localparam int C_IDP    = 0;
  localparam int C_OT     = 1;
  localparam int C_OV     = 2;
  localparam int C_UV     = 3;
  localparam int C_OC     = 4;
  typedef logic [CAUSE_N-1:0] cause_t;
endpackage

// File: rtl/fs_flag_sync.sv
module fs_flag_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fs_run_detect.sv
module fs_run_detect #(
  parameter int RUN_LEN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  output logic stuck
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);

  logic [CW-1:0] run_cnt;
  logic          last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      last_bit <= 1'b0;
    end else if (in_valid) begin
      last_bit <= in_bit;
      if (run_cnt != '0 && in_bit == last_bit) begin
        if (run_cnt != RUN_MAX) run_cnt <= run_cnt + 1'b1;
      end else begin
        run_cnt <= CW'(1);
      end
    end
  end

  assign stuck = (run_cnt == RUN_MAX);

  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && run_cnt != '0 && in_bit != last_bit) |=> !stuck);
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(stuck) && $stable(run_cnt)));
  assert_rise_on_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stuck) |-> $past(in_valid));
endmodule

// File: rtl/fs_ot_lockout.sv
module fs_ot_lockout #(
  parameter int HOLD = 614400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ot_sync,
  output logic active
);
  localparam int TW = (HOLD > 2) ? $clog2(HOLD) : 1;
  localparam logic [TW-1:0] T_END = TW'(HOLD - 1);

  logic [TW-1:0] timer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      timer  <= '0;
    end else if (!active) begin
      if (ot_sync) begin
        active <= 1'b1;
        timer  <= '0;
      end
    end else if (timer == T_END) begin
      timer <= '0;
      if (!ot_sync) active <= 1'b0;
    end else begin
      timer <= timer + 1'b1;
    end
  end

  assert_ot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && timer != T_END) |=> active);
  assert_ot_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && timer == T_END && !ot_sync) |=> !active);
  assert_ot_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && timer == T_END && ot_sync) |=> (active && timer == '0));
endmodule

// File: rtl/fs_prot_supervisor.sv
module fs_prot_supervisor
  import fs_pkg::*;
#(
  parameter int RUN_LEN     = 128,
  parameter int OT_HOLD     = 614400,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pdm_valid,
  input  logic               pdm_bit,
  output logic               pdm_ready,
  input  logic               ot_flag,
  input  logic               ov_flag,
  input  logic               uv_flag,
  input  logic               oc_flag,
  output logic               fault,
  output logic [CAUSE_N-1:0] cause,
  output logic               out_en
);
  logic [3:0] flags_s;
  logic       idp;
  logic       ot_active;
  cause_t     cause_w;

  fs_flag_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({oc_flag, uv_flag, ov_flag, ot_flag}),
    .q     (flags_s)
  );

  fs_run_detect #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (pdm_valid),
    .in_bit   (pdm_bit),
    .stuck    (idp)
  );

  fs_ot_lockout #(.HOLD(OT_HOLD)) u_ot (
    .clk     (clk),
    .rst_n   (rst_n),
    .ot_sync (flags_s[0]),
    .active  (ot_active)
  );

  always_comb begin
    cause_w        = '0;
    cause_w[C_IDP] = idp;
    cause_w[C_OT]  = ot_active;
    cause_w[C_OV]  = flags_s[1];
    cause_w[C_UV]  = flags_s[2];
    cause_w[C_OC]  = flags_s[3];
  end

  assign cause     = cause_w;
  assign fault     = |cause_w;
  assign out_en    = ~fault;
  assign pdm_ready = 1'b1;

  assert_ot_disables_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause[C_OT]) |-> (!out_en && fault));
  assert_ready_R4: assert property (@(posedge clk) disable iff (!rst_n) pdm_ready);

  if (SYNC_STAGES == 2) begin : g_chk
    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= '0;
      else if (age != 2'd3) age <= age + 1'b1;
    end
    assert_ov_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> (cause[C_OV] == $past(ov_flag, 2)));
    assert_oc_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> (cause[C_OC] == $past(oc_flag, 2)));
  end
endmodule

// File: tb/test_fs_prot_supervisor.sv
module test_fs_prot_supervisor;
  localparam int HOLD = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pdm_valid = 1'b0, pdm_bit = 1'b0;
  logic ot_flag = 1'b0, ov_flag = 1'b0, uv_flag = 1'b0, oc_flag = 1'b0;
  logic pdm_ready, fault, out_en;
  logic [4:0] cause;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct { logic [4:0] exp; string tag; } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  fs_prot_supervisor #(.RUN_LEN(128), .OT_HOLD(HOLD), .SYNC_STAGES(2)) i_fs_prot_supervisor (
    .clk(clk), .rst_n(rst_n), .pdm_valid(pdm_valid), .pdm_bit(pdm_bit),
    .pdm_ready(pdm_ready), .ot_flag(ot_flag), .ov_flag(ov_flag),
    .uv_flag(uv_flag), .oc_flag(oc_flag), .fault(fault), .cause(cause),
    .out_en(out_en)
  );

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_c(logic [4:0] e, string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic send(logic b, int n);
    for (int i = 0; i < n; i++) begin
      pdm_valid = 1'b1;
      pdm_bit   = b;
      tick();
    end
    pdm_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        total++;
        if (cause !== it.exp || fault !== (|it.exp) || out_en !== ~(|it.exp) || pdm_ready !== 1'b1) begin
          bad++;
          $display("FAIL %s: cause=%b fault=%b out_en=%b ready=%b expected cause=%b fault=%b out_en=%b ready=1",
                   it.tag, cause, fault, out_en, pdm_ready, it.exp, |it.exp, ~(|it.exp));
        end
      end
    end
  end

  initial begin
    #3_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    expect_c(5'b00000, "R1 reset state");

    // alternating stream never trips (R2)
    for (int i = 0; i < 300; i++) begin
      pdm_valid = 1'b1;
      pdm_bit   = i[0];
      tick();
    end
    pdm_valid = 1'b0;
    expect_c(5'b00000, "R2 alternating");

    // last bit was 1; zeros run of 127 then 128 (R2)
    send(1'b0, 127);
    expect_c(5'b00000, "R2 run of 127 zeros");
    send(1'b0, 1);
    expect_c(5'b00001, "R2 run of 128 zeros");
    send(1'b1, 1);
    expect_c(5'b00000, "R3 differing bit clears");

    // ones run with a gap in the middle (R4)
    send(1'b1, 100);
    tick(20);
    expect_c(5'b00000, "R4 gap does not extend run");
    send(1'b1, 26);
    expect_c(5'b00000, "R4 run of 127 ones across gap");
    send(1'b1, 1);
    expect_c(5'b00001, "R4 run of 128 ones across gap");
    tick(10);
    expect_c(5'b00001, "R4 idle holds stuck cause");
    send(1'b0, 1);
    expect_c(5'b00000, "R3 zero after ones clears");

    // pass-through flags (R5, R6)
    ov_flag = 1'b1;
    tick();
    expect_c(5'b00000, "R5 ov one edge");
    tick();
    expect_c(5'b00100, "R5 ov two edges");
    uv_flag = 1'b1;
    tick(2);
    expect_c(5'b01100, "R6 ov+uv combined");
    oc_flag = 1'b1;
    ov_flag = 1'b0;
    tick();
    expect_c(5'b01100, "R5 change pending after one edge");
    tick();
    expect_c(5'b11000, "R6 uv+oc, ov released");
    uv_flag = 1'b0;
    oc_flag = 1'b0;
    tick();
    expect_c(5'b11000, "R5 fall pending after one edge");
    tick();
    expect_c(5'b00000, "R5 flags released");

    // over-temperature one-cycle pulse (R7)
    ot_flag = 1'b1;
    tick();
    ot_flag = 1'b0;
    expect_c(5'b00000, "R7 ot after edge 1");
    tick();
    expect_c(5'b00000, "R7 ot after edge 2");
    tick();
    expect_c(5'b00010, "R7 ot latched after edge 3");
    tick(HOLD - 1);
    expect_c(5'b00010, "R7 ot held last cycle");
    tick();
    expect_c(5'b00000, "R7 ot released");

    // over-temperature held through expiry (R8)
    ot_flag = 1'b1;
    tick(3);
    expect_c(5'b00010, "R8 ot latched");
    tick(HOLD - 1);
    expect_c(5'b00010, "R8 before expiry");
    tick();
    expect_c(5'b00010, "R8 restarted at expiry");
    ot_flag = 1'b0;
    tick(HOLD - 1);
    expect_c(5'b00010, "R8 second hold last cycle");
    tick();
    expect_c(5'b00000, "R8 released after second hold");

    tick(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule